// File: doc/BRIEF.md
# Serial Configuration Register Receiver

This block is a write-only slave on a two-wire serial bus (one data line, one clock line). It watches both lines with the system clock, recognises start and stop conditions, and shifts in bytes MSB first on rising edges of the serial clock. A transfer carries an address byte, two framing bytes whose values do not matter, and up to eight data bytes. When the address matches, the data bytes land in an eight-entry configuration register bank. The bank's contents are driven out continuously as one flat parallel bus.

The bank powers up with fixed default values, so a system that never talks to the block still gets a usable configuration. One bit of the bank belongs to a test function that must stay off. The block stores that bit as 0 whatever value arrives on the bus. The block answers each byte of a matching frame by pulling the data line low for the ninth clock. It never drives anything else, and it has no read path. The system clock must run at least eight times faster than the serial clock.

Top module: `ser_cfg_rx`

## Requirements
- R1: After reset, register k (bits [8k+7:8k] of `cfg_o`) holds byte k of 64'h8421F00F5A33C3E7, so register 0 is 8'hE7 and register 7 is 8'h84.
- R2: Only a first byte equal to 8'hD2 (7-bit address 7'b1101001 followed by write bit 0) selects the block. Any other first byte, including 8'hD3, leaves every register unchanged and gets no acknowledge on any byte until the next start.
- R3: After a matching address, the second and third bytes are acknowledged. Their values are stored nowhere.
- R4: Bytes four to eleven of a matching frame are written, in order, to registers 0 to 7. Each byte is assembled MSB first from bits sampled on rising serial clock edges.
- R5: A data byte is committed as soon as its eighth bit is sampled, before its acknowledge or any stop. A frame cut short by a stop updates only the registers whose bytes arrived, and registers change at no other time.
- R6: Bit 3 of register 7 (`cfg_o[59]`) always reads 0, even when a 1 is written to it.
- R7: In a matching frame, bytes after the eighth data byte are acknowledged but change no register.
- R8: A repeated start (a start with no stop before it) returns the receiver to the address phase, so the next data byte goes to register 0.
- R9: The acknowledge drive (`sda_pull_o` = 1 means pull the data line low) is asserted only while the serial clock is low at the start of the ninth bit slot. It is held through that slot's high phase and released once the serial clock falls again. A stop condition releases it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin (wired level) |
| sda_pull_o | output | 1 | 1 = pull the data line low (acknowledge) |
| cfg_o | output | 64 | Register bank, register k on bits [8k+7:8k] |

## Verification
The bench sends the read form of the address (8'hD3) and an unrelated address. A decoder that ignored the direction bit, or did not gate writes on the match, would load those data bytes and acknowledge them. It cuts a frame short after three data bytes and also reads register 0 just after its eighth bit, before any stop. That exposes logic that buffers bytes until the stop, or that lets a missing byte clear a register. It sends two surplus bytes to catch an index that wraps onto register 0, and a repeated start to catch a byte counter that keeps counting. It writes all ones to show that the test bit stays 0.

// File: rtl/cfg_rx_pkg.sv
`timescale 1ns/1ps
package cfg_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_BITS,
    RX_ACK_WAIT,
    RX_ACK_LOW,
    RX_ACK_HIGH,
    RX_SKIP
  } rx_state_e;

  localparam int unsigned HDR_BYTES = 2;
endpackage

// File: rtl/cfg_rx_linecond.sv
`timescale 1ns/1ps
module cfg_rx_linecond #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] line_in;
  logic [1:0] line_lvl;
  logic [1:0] line_prev;

  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] stage_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '1;
      else        stage_q <= {stage_q[SYNC_STAGES-2:0], line_in[g]};
    end
    assign line_lvl[g] = stage_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_prev <= '1;
    else        line_prev <= line_lvl;
  end

  assign scl_lvl   = line_lvl[0];
  assign sda_lvl   = line_lvl[1];
  assign scl_rise  = line_lvl[0] & ~line_prev[0];
  assign scl_fall  = ~line_lvl[0] & line_prev[0];
  assign start_det = line_lvl[0] & line_prev[0] & line_prev[1] & ~line_lvl[1];
  assign stop_det  = line_lvl[0] & line_prev[0] & ~line_prev[1] & line_lvl[1];
endmodule

// File: rtl/cfg_rx_frame.sv
`timescale 1ns/1ps
module cfg_rx_frame
  import cfg_rx_pkg::*;
#(
  parameter logic [7:0]  ADDR_BYTE = 8'hD2,
  parameter int unsigned NREG      = 8,
  parameter int unsigned IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_pull,
  output logic             matched
);
  localparam logic [IDX_W-1:0] IDX_HDR = IDX_W'(HDR_BYTES + 1);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(HDR_BYTES + 1 + NREG);

  rx_state_e        st_q, st_d;
  logic [2:0]       bit_q, bit_d;
  logic [IDX_W-1:0] byte_q, byte_d;
  logic [7:0]       sh_q, sh_d;
  logic             match_q, match_d;
  logic             addr_ok;

  assign addr_ok = ({sh_q[6:0], sda_lvl} == ADDR_BYTE);

  always_comb begin
    st_d    = st_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    sh_d    = sh_q;
    match_d = match_q;
    wr_en   = 1'b0;
    wr_data = {sh_q[6:0], sda_lvl};
    wr_idx  = byte_q - IDX_HDR;
    if (start_det) begin
      st_d    = RX_BITS;
      bit_d   = '0;
      byte_d  = '0;
      match_d = 1'b0;
    end else if (stop_det) begin
      st_d = RX_IDLE;
    end else begin
      unique case (st_q)
        RX_BITS: if (scl_rise) begin
          sh_d  = {sh_q[6:0], sda_lvl};
          bit_d = bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            if (byte_q != IDX_END) byte_d = byte_q + IDX_W'(1);
            if (byte_q == '0) begin
              match_d = addr_ok;
              st_d    = addr_ok ? RX_ACK_WAIT : RX_SKIP;
            end else begin
              st_d  = RX_ACK_WAIT;
              wr_en = match_q && (byte_q >= IDX_HDR) && (byte_q < IDX_END);
            end
          end
        end
        RX_ACK_WAIT: if (scl_fall) st_d = RX_ACK_LOW;
        RX_ACK_LOW:  if (scl_rise) st_d = RX_ACK_HIGH;
        RX_ACK_HIGH: if (scl_fall) st_d = RX_BITS;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      bit_q   <= '0;
      byte_q  <= '0;
      sh_q    <= '0;
      match_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
      sh_q    <= sh_d;
      match_q <= match_d;
    end
  end

  assign sda_pull = match_q && ((st_q == RX_ACK_LOW) || (st_q == RX_ACK_HIGH));
  assign matched  = match_q;
endmodule

// File: rtl/cfg_rx_regbank.sv
`timescale 1ns/1ps
module cfg_rx_regbank #(
  parameter int unsigned    NREG     = 8,
  parameter int unsigned    IDX_W    = 4,
  parameter logic [8*8-1:0] DEFAULTS = 64'h8421F00F5A33C3E7,
  parameter int unsigned    RSVD_POS = 59
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [7:0]        wr_data,
  output logic [NREG*8-1:0] cfg
);
  localparam logic [NREG*8-1:0] KEEP_MASK = ~((NREG*8)'(1) << RSVD_POS);

  logic [NREG*8-1:0] bank_q, bank_d;

  always_comb begin
    bank_d = bank_q;
    for (int k = 0; k < NREG; k++) begin
      if (wr_en && (wr_idx == IDX_W'(k))) bank_d[k*8 +: 8] = wr_data;
    end
    bank_d = bank_d & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bank_q <= DEFAULTS & KEEP_MASK;
    else if (wr_en) bank_q <= bank_d;
  end

  assign cfg = bank_q;
endmodule

// File: rtl/ser_cfg_rx.sv
`timescale 1ns/1ps
module ser_cfg_rx #(
  parameter logic [7:0]  ADDR_BYTE   = 8'hD2,
  parameter int unsigned NREG        = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [63:0] DEFAULTS    = 64'h8421F00F5A33C3E7,
  parameter int unsigned RSVD_POS    = 59
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_pull_o,
  output logic [NREG*8-1:0] cfg_o
);
  localparam int unsigned IDX_W = $clog2(cfg_rx_pkg::HDR_BYTES + NREG + 2);

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic             scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en, matched;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  cfg_rx_linecond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  cfg_rx_frame #(.ADDR_BYTE(ADDR_BYTE), .NREG(NREG), .IDX_W(IDX_W)) u_frame (
    .clk(clk), .rst_n(rst_sync_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sda_pull(sda_pull_o), .matched(matched)
  );

  cfg_rx_regbank #(.NREG(NREG), .IDX_W(IDX_W), .DEFAULTS(DEFAULTS),
                   .RSVD_POS(RSVD_POS)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .cfg(cfg_o)
  );
endmodule

// File: rtl/ser_cfg_rx_chk.sv
`timescale 1ns/1ps
module ser_cfg_rx_chk #(
  parameter int unsigned W        = 64,
  parameter int unsigned RSVD_POS = 59
) (
  input logic         clk,
  input logic         rst_n,
  input logic         scl_lvl,
  input logic         stop_det,
  input logic         sda_pull,
  input logic         wr_en,
  input logic         matched,
  input logic [W-1:0] cfg
);
  AST_PULL_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_lvl); // R9
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull); // R9
  AST_WRITE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> matched); // R2
  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg)); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[RSVD_POS]); // R6
endmodule

bind ser_cfg_rx ser_cfg_rx_chk #(.W(NREG*8), .RSVD_POS(RSVD_POS)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .scl_lvl(scl_lvl), .stop_det(stop_det),
  .sda_pull(sda_pull_o), .wr_en(wr_en), .matched(matched), .cfg(cfg_o)
);

// File: tb/ser_cfg_rx_tb_top.sv
`timescale 1ns/1ps
module ser_cfg_rx_tb_top;
  localparam logic [63:0] DEF = 64'h8421F00F5A33C3E7;
  localparam logic [63:0] RSVD_MASK = ~(64'd1 << 59);
  // vector: {addr[7:0], count[3:0], data[63:0]} ; data byte k at [8k+7:8k]
  localparam logic [75:0] VEC [6] = '{
    {8'hD2, 4'd8, 64'h0123456789ABCDEF},
    {8'hD3, 4'd8, 64'hFFFFFFFFFFFFFFFF},
    {8'hA4, 4'd8, 64'h1111111111111111},
    {8'hD2, 4'd3, 64'h00000000003CA55A},
    {8'hD2, 4'd8, 64'hFFFFFFFFFFFFFFFF},
    {8'hD2, 4'd8, 64'h0000000000000000}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic m_scl, m_sda;
  logic sda_pull;
  logic [63:0] cfg;
  logic [63:0] exp_cfg;
  int n_tests = 0;
  int n_fail  = 0;
  wire sda_line = m_sda & ~sda_pull;

  always #5 clk = ~clk;

  ser_cfg_rx dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .cfg_o(cfg)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] got,
                       input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic hwait();
    repeat (16) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; hwait();
    m_sda = 1'b0; hwait();
    m_scl = 1'b0;
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; hwait();
    m_scl = 1'b1; hwait();
    m_sda = 1'b0; hwait();
    m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hwait();
    m_scl = 1'b1; hwait();
    m_sda = 1'b1; hwait();
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hwait();
      m_scl = 1'b1; hwait();
      m_scl = 1'b0;
    end
    m_sda = 1'b1; hwait();
    m_scl = 1'b1;
    repeat (8) @(posedge clk);
    #1 a = sda_pull;
    hwait();
    m_scl = 1'b0;
  endtask

  task automatic model_write(input int k, input logic [7:0] d);
    exp_cfg[k*8 +: 8] = d;
    exp_cfg = exp_cfg & RSVD_MASK;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got %h expected %h", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [10:0] acks;
    logic a;
    m_scl = 1'b1; m_sda = 1'b1; rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    exp_cfg = DEF & RSVD_MASK;
    check(cfg == exp_cfg, "R1 reset defaults", cfg, exp_cfg);
    check(sda_pull == 1'b0, "R9 idle release", 64'(sda_pull), 0);

    // table-driven frames: R2 R3 R4 R5 R6
    foreach (VEC[v]) begin
      logic [7:0] ad;
      logic [3:0] cnt;
      logic [63:0] dat;
      logic [10:0] exp_ack;
      {ad, cnt, dat} = VEC[v];
      acks = '0;
      bus_start();
      tx_byte(ad, a);          acks[0] = a;
      tx_byte(8'h5C, a);       acks[1] = a;  // command byte, value ignored (R3)
      tx_byte(8'hE7, a);       acks[2] = a;  // count byte, value ignored (R3)
      for (int k = 0; k < int'(cnt); k++) begin
        tx_byte(dat[k*8 +: 8], a);
        acks[3+k] = a;
        if (ad == 8'hD2) model_write(k, dat[k*8 +: 8]);
      end
      bus_stop();
      repeat (4) @(posedge clk);
      #1;
      exp_ack = '0;
      for (int k = 0; k < 3 + int'(cnt); k++) exp_ack[k] = (ad == 8'hD2);
      check(acks == exp_ack, "R2/R3 acknowledge pattern", 64'(acks), 64'(exp_ack));
      check(cfg == exp_cfg, "R4/R5/R6 register bank after frame", cfg, exp_cfg);
    end
    check(cfg[59] == 1'b0, "R6 reserved bit after all-ones write", 64'(cfg[59]), 0);

    // R5: commit right after eighth bit, before stop
    bus_start();
    tx_byte(8'hD2, a); tx_byte(8'h00, a); tx_byte(8'h00, a);
    tx_byte(8'h77, a);
    model_write(0, 8'h77);
    check(cfg == exp_cfg, "R5 commit before stop", cfg, exp_cfg);
    bus_stop();

    // R7: surplus bytes acked and discarded
    bus_start();
    tx_byte(8'hD2, a); tx_byte(8'h01, a); tx_byte(8'h08, a);
    for (int k = 0; k < 8; k++) begin
      tx_byte(8'h10 + 8'(k), a);
      model_write(k, 8'h10 + 8'(k));
    end
    acks = '0;
    tx_byte(8'hEE, a); acks[0] = a;
    tx_byte(8'hEE, a); acks[1] = a;
    bus_stop();
    repeat (4) @(posedge clk);
    #1;
    check(acks[1:0] == 2'b11, "R7 surplus bytes acknowledged", 64'(acks[1:0]), 3);
    check(cfg == exp_cfg, "R7 surplus bytes discarded", cfg, exp_cfg);

    // R8: repeated start returns to address phase
    bus_start();
    tx_byte(8'hD2, a); tx_byte(8'h00, a); tx_byte(8'h00, a);
    tx_byte(8'h99, a);
    model_write(0, 8'h99);
    bus_rstart();
    tx_byte(8'hD2, a); tx_byte(8'h00, a); tx_byte(8'h00, a);
    tx_byte(8'h42, a);
    model_write(0, 8'h42);
    bus_stop();
    repeat (4) @(posedge clk);
    #1;
    check(cfg == exp_cfg, "R8 repeated start restarts framing", cfg, exp_cfg);
    check(sda_pull == 1'b0, "R9 released after stop", 64'(sda_pull), 0);

    // R1: reset mid-operation restores defaults
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    exp_cfg = DEF & RSVD_MASK;
    check(cfg == exp_cfg, "R1 defaults after second reset", cfg, exp_cfg);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule